// File: doc/BRIEF.md
# Pointer-Addressed Packet Buffer Port

This block lets a host reach a 2048 x 8 packet buffer without mapping the whole buffer into its address space. The host sees three registers: a low pointer byte, a high pointer byte, and a data register. Every data access goes to the buffer location held in the pointer. The high pointer byte also holds a transfer-direction flag and an auto-advance flag. With auto-advance on, the host can stream a packet through the data register one access after another.

The host port runs in byte mode or word mode, chosen by a mode input. In word mode one data access moves two neighbouring buffer bytes. Pointer bit 0 is then no longer an address bit. Instead it selects whether the two bytes are exchanged on their way through the data register.

When the direction flag says "read", writing the low pointer byte starts a fetch of the addressed location into the data register. Data is therefore ready before the host's first data read. With auto-advance on, each data read also fetches the next location. The buffer sits inside the block as a single-port RAM with one cycle of read latency.

Top module: `bufram_port`

## Requirements
- R1: After a synchronous reset, both pointer registers read back 0x00. Auto-advance is off and the direction is write.
- R2: Register selects are 0 = data, 1 = low pointer, 2 = high pointer. The low pointer reads back all 8 written bits. The high pointer keeps bit 7 (1 = read direction), bit 6 (1 = auto-advance) and bits 2:0 (address bits 10:8), and reads 0 in bits 5:3.
- R3: In byte mode, a data write stores host_wdata[7:0] at the 11-bit pointer address. A read-direction fetch makes that byte available on host_rdata[7:0] within three clock cycles after the strobe cycle.
- R4: A fetch starts on a low-pointer write while the direction is read. Writing the high pointer never starts a fetch, so the data register keeps its earlier contents.
- R5: In byte mode with auto-advance, each data access adds 1 to the 11-bit pointer. The pointer wraps from 0x7FF to 0x000.
- R6: In word mode with swap off (pointer bit 0 = 0), the data register carries the byte at the even address E in bits 7:0 and the byte at E+1 in bits 15:8. E is the pointer with bit 0 cleared. This holds for both writes and reads.
- R7: In word mode with pointer bit 0 = 1, the two bytes are exchanged on writes and reads. The buffer address E is unchanged.
- R8: In word mode with auto-advance, each data access adds 2 to the address and leaves pointer bit 0 (the swap flag) unchanged.
- R9: With read direction and auto-advance, each data read returns the current location and fetches the next one, so successive reads stream consecutive buffer data.
- R10: With auto-advance off, a data access leaves the pointer unchanged. A data read with auto-advance off does not fetch again.
- R11: In byte mode, a data read returns 0 in host_rdata[15:8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_mode | input | 1 | 1 = 16-bit host access, 0 = 8-bit |
| host_sel | input | 2 | Register select: 0 data, 1 low pointer, 2 high pointer |
| host_wr | input | 1 | One-cycle write strobe |
| host_rd | input | 1 | One-cycle read strobe; the access ends in the strobe cycle |
| host_wdata | input | 16 | Write data (pointer writes use bits 7:0) |
| host_rdata | output | 16 | Read data for the selected register |

## Verification
The main function is first tried with a set of single bytes at scattered addresses: page boundaries, the top address, and alternating bit patterns. Each is written and then fetched back through a low-pointer write, which separates correct address composition from mixed-up high bits. Streaming runs with auto-advance, in both byte and word mode, separate the step size and the fetch of the following location from a stale data register. Word transfers with the swap flag clear and set, checked both in word mode and byte by byte in byte mode, separate lane order from address alignment. Wrap at the top of the buffer and a high-pointer write that must not fetch cover the edges.

// File: rtl/bufram_pkg.sv
// Package: shared register selects and sizing helpers for the buffer port.
// Assumes an 8-bit low pointer byte; the high pointer byte carries the rest.
package bufram_pkg;
    localparam logic [1:0] SEL_DATA = 2'd0;
    localparam logic [1:0] SEL_PLO  = 2'd1;
    localparam logic [1:0] SEL_PHI  = 2'd2;

    localparam int HI_DIR_BIT  = 7;
    localparam int HI_AINC_BIT = 6;
endpackage

// File: rtl/bufram_spram.sv
// Module: single-port synchronous RAM used as the packet buffer.
// Assumes one access per cycle; read data appears the cycle after en.
module bufram_spram #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Storage write or registered read.
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem[addr] <= wdata;
            else    rdata     <= mem[addr];
        end
    end
endmodule

// File: rtl/bufram_ptr.sv
// Module: pointer register pair with direction, auto-advance and step logic.
// Assumes at most one of lo_wr, hi_wr, step in a cycle (one host strobe).
module bufram_ptr #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_mode,
    input  logic              lo_wr,
    input  logic              hi_wr,
    input  logic [7:0]        wdata,
    input  logic              step,
    output logic [ADDR_W-1:0] ptr_q,
    output logic [ADDR_W-1:0] ptr_nx,
    output logic              dir_rd,
    output logic              ainc,
    output logic [7:0]        hi_view
);
    import bufram_pkg::*;

    localparam int HI_W  = ADDR_W - 8;
    localparam int PAD_W = 6 - HI_W;

    logic [ADDR_W-2:0] word_nx;

    // Next pointer value from host writes or an auto-advance step.
    always_comb begin
        word_nx = ptr_q[ADDR_W-1:1] + (ADDR_W-1)'(1);
        ptr_nx  = ptr_q;
        if (lo_wr)
            ptr_nx = {ptr_q[ADDR_W-1:8], wdata};
        else if (hi_wr)
            ptr_nx = {wdata[HI_W-1:0], ptr_q[7:0]};
        else if (step && ainc)
            ptr_nx = word_mode ? {word_nx, ptr_q[0]} : ptr_q + ADDR_W'(1);
    end

    // Pointer and control flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            dir_rd <= 1'b0;
            ainc   <= 1'b0;
        end else begin
            ptr_q <= ptr_nx;
            if (hi_wr) begin
                dir_rd <= wdata[HI_DIR_BIT];
                ainc   <= wdata[HI_AINC_BIT];
            end
        end
    end

    // Readback image of the high pointer byte.
    always_comb hi_view = {dir_rd, ainc, {PAD_W{1'b0}}, ptr_q[ADDR_W-1:8]};
endmodule

// File: rtl/bufram_seq.sv
// Module: RAM access sequencer issuing one (byte mode) or two (word mode)
// consecutive byte operations from a latched base address.
// Assumes a new start only after busy has dropped.
module bufram_seq #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_rd,
    input  logic              start_wr,
    input  logic              two,
    input  logic [ADDR_W-1:0] base,
    input  logic [15:0]       wbytes,
    output logic              ram_en,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [7:0]        ram_wdata,
    output logic              cap_vld,
    output logic              cap_idx,
    output logic              busy
);
    logic              active;
    logic              is_wr;
    logic              idx;
    logic              last_idx;
    logic [ADDR_W-1:0] base_q;
    logic [15:0]       wb_q;

    // Operation state: latch a request, then walk its byte operations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            is_wr    <= 1'b0;
            idx      <= 1'b0;
            last_idx <= 1'b0;
            base_q   <= '0;
            wb_q     <= '0;
        end else if (start_rd || start_wr) begin
            active   <= 1'b1;
            is_wr    <= start_wr;
            idx      <= 1'b0;
            last_idx <= two;
            base_q   <= base;
            wb_q     <= wbytes;
        end else if (active) begin
            if (idx == last_idx) active <= 1'b0;
            else                 idx    <= 1'b1;
        end
    end

    // Capture tag that follows a read by one cycle of RAM latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_vld <= 1'b0;
            cap_idx <= 1'b0;
        end else begin
            cap_vld <= active && !is_wr;
            cap_idx <= idx;
        end
    end

    // RAM command drive for the current byte operation.
    always_comb begin
        ram_en    = active;
        ram_we    = active && is_wr;
        ram_addr  = base_q + ADDR_W'(idx);
        ram_wdata = idx ? wb_q[15:8] : wb_q[7:0];
        busy      = active || cap_vld;
    end
endmodule

// File: rtl/bufram_port.sv
// Module: host-facing buffer port. Decodes register accesses, keeps the
// data register, and connects the pointer, sequencer and RAM.
// Assumes host strobes are at least four cycles apart and the word mode
// input changes only while no access is in flight.
module bufram_port #(
    parameter int ADDR_W = 11
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        word_mode,
    input  logic [1:0]  host_sel,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata
);
    import bufram_pkg::*;

    logic              lo_wr, hi_wr, dat_wr, dat_rd, step;
    logic [ADDR_W-1:0] ptr_q, ptr_nx, seq_base;
    logic              ptr_dir, ptr_ainc;
    logic [7:0]        hi_view;
    logic              start_rd;
    logic [15:0]       wr_raw;
    logic              ram_en, ram_we;
    logic [ADDR_W-1:0] ram_addr;
    logic [7:0]        ram_wdata, ram_rdata;
    logic              cap_vld, cap_idx, seq_busy;
    logic [15:0]       dreg;
    logic              swap;

    // Host strobe decode and request routing.
    always_comb begin
        lo_wr    = host_wr && host_sel == SEL_PLO;
        hi_wr    = host_wr && host_sel == SEL_PHI;
        dat_wr   = host_wr && host_sel == SEL_DATA;
        dat_rd   = host_rd && host_sel == SEL_DATA;
        step     = dat_wr || dat_rd;
        swap     = word_mode && ptr_q[0];
        start_rd = ptr_dir && (lo_wr || (dat_rd && ptr_ainc));
        seq_base = dat_wr ? ptr_q : ptr_nx;
        if (word_mode) seq_base[0] = 1'b0;
        wr_raw   = swap ? {host_wdata[7:0], host_wdata[15:8]} : host_wdata;
    end

    bufram_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_mode (word_mode),
        .lo_wr     (lo_wr),
        .hi_wr     (hi_wr),
        .wdata     (host_wdata[7:0]),
        .step      (step),
        .ptr_q     (ptr_q),
        .ptr_nx    (ptr_nx),
        .dir_rd    (ptr_dir),
        .ainc      (ptr_ainc),
        .hi_view   (hi_view)
    );

    bufram_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_rd  (start_rd),
        .start_wr  (dat_wr),
        .two       (word_mode),
        .base      (seq_base),
        .wbytes    (wr_raw),
        .ram_en    (ram_en),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata),
        .cap_vld   (cap_vld),
        .cap_idx   (cap_idx),
        .busy      (seq_busy)
    );

    bufram_spram #(.AW(ADDR_W), .DW(8)) u_ram (
        .clk   (clk),
        .en    (ram_en),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (ram_rdata)
    );

    // Data register: loaded by host writes or by fetched RAM bytes.
    always_ff @(posedge clk) begin
        if (dat_wr) begin
            if (word_mode) dreg       <= wr_raw;
            else           dreg[7:0]  <= host_wdata[7:0];
        end else if (cap_vld) begin
            if (cap_idx)   dreg[15:8] <= ram_rdata;
            else           dreg[7:0]  <= ram_rdata;
        end
    end

    // Read data multiplexer for the selected register.
    always_comb begin
        case (host_sel)
            SEL_DATA: host_rdata = word_mode ? (swap ? {dreg[7:0], dreg[15:8]} : dreg)
                                             : {8'h00, dreg[7:0]};
            SEL_PLO:  host_rdata = {8'h00, ptr_q[7:0]};
            SEL_PHI:  host_rdata = {8'h00, hi_view};
            default:  host_rdata = 16'h0000;
        endcase
    end
endmodule

// File: rtl/bufram_port_chk.sv
// Module: property checker for the buffer port, bound into bufram_port.
// Assumes it observes the pointer register and the sequencer's RAM command.
module bufram_port_chk #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              word_mode,
    input logic [1:0]        host_sel,
    input logic              host_wr,
    input logic              host_rd,
    input logic [ADDR_W-1:0] ptr_q,
    input logic              ainc,
    input logic              seq_busy,
    input logic              ram_en
);
    import bufram_pkg::*;

    logic data_acc;
    always_comb data_acc = (host_wr || host_rd) && host_sel == SEL_DATA;

    a_r1_reset_ptr: assert property (@(posedge clk)
        !rst_n |=> (ptr_q == '0 && !ainc));

    a_r10_hold_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && !ainc) |=> $stable(ptr_q));

    a_r5_step_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && ainc && !word_mode) |=> ptr_q == ADDR_W'($past(ptr_q) + 1'b1));

    a_r8_step_word: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && ainc && word_mode) |=>
            (ptr_q[ADDR_W-1:1] == (ADDR_W-1)'($past(ptr_q[ADDR_W-1:1]) + 1'b1)
             && ptr_q[0] == $past(ptr_q[0])));

    a_r4_hi_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == SEL_PHI && !seq_busy) |=> !ram_en);
endmodule

bind bufram_port bufram_port_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_mode (word_mode),
    .host_sel  (host_sel),
    .host_wr   (host_wr),
    .host_rd   (host_rd),
    .ptr_q     (ptr_q),
    .ainc      (ptr_ainc),
    .seq_busy  (seq_busy),
    .ram_en    (ram_en)
);

// File: tb/sim_bufram_port.sv
`timescale 1ns/1ps
module sim_bufram_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_mode = 1'b0;
    logic [1:0]  host_sel = 2'd0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [15:0] host_wdata = 16'h0;
    logic [15:0] host_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Byte vectors: {address[10:0], data[7:0]}
    localparam logic [18:0] VEC [6] = '{
        {11'h000, 8'h5A}, {11'h7FF, 8'hC3}, {11'h155, 8'h01},
        {11'h2AA, 8'hFE}, {11'h0FF, 8'h80}, {11'h100, 8'h7F}
    };

    bufram_port u0 (
        .clk(clk), .rst_n(rst_n), .word_mode(word_mode), .host_sel(host_sel),
        .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
        .host_rdata(host_rdata)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk);
        host_sel = sel; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic bus_rd(input logic [1:0] sel, output logic [15:0] d);
        @(negedge clk);
        host_sel = sel; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state of the pointer registers
        bus_rd(2'd1, r); chk("R1 low ptr", r, 16'h0000);
        bus_rd(2'd2, r); chk("R1 high ptr", r, 16'h0000);
        // R2: readback of pointer bytes
        bus_wr(2'd2, 16'h00FF); bus_rd(2'd2, r); chk("R2 high ptr", r, 16'h00C7);
        bus_wr(2'd1, 16'h00A5); bus_rd(2'd1, r); chk("R2 low ptr", r, 16'h00A5);

        // R3: vector table, write each byte then fetch it back
        for (int i = 0; i < 6; i++) begin
            bus_wr(2'd2, {13'h0, VEC[i][18:16]});
            bus_wr(2'd1, {8'h0, VEC[i][15:8]});
            bus_wr(2'd0, {8'h0, VEC[i][7:0]});
        end
        for (int i = 0; i < 6; i++) begin
            bus_wr(2'd2, {8'h0, 5'b10000, VEC[i][18:16]});
            bus_wr(2'd1, {8'h0, VEC[i][15:8]});
            bus_rd(2'd0, r);
            chk("R3 R11 byte fetch", r, {8'h00, VEC[i][7:0]});
        end

        // R4: high pointer write does not fetch
        bus_wr(2'd2, 16'h0080); bus_wr(2'd1, 16'h0000);
        bus_rd(2'd0, r); chk("R4 fetch on low write", r, 16'h005A);
        bus_wr(2'd2, 16'h0087);
        bus_rd(2'd0, r); chk("R4 no fetch on high write", r, 16'h005A);
        bus_wr(2'd1, 16'h00FF);
        bus_rd(2'd0, r); chk("R4 fetch after low write", r, 16'h00C3);

        // R10: no auto-advance leaves pointer and data unchanged
        bus_rd(2'd0, r); chk("R10 repeat read", r, 16'h00C3);
        bus_rd(2'd1, r); chk("R10 pointer held", r, 16'h00FF);

        // R5 R9: byte streaming with auto-advance
        bus_wr(2'd2, 16'h0043); bus_wr(2'd1, 16'h0010);
        for (int i = 0; i < 4; i++) bus_wr(2'd0, 16'h0011 + 16'(i));
        bus_rd(2'd1, r); chk("R5 advance by one", r, 16'h0014);
        bus_wr(2'd2, 16'h00C3); bus_wr(2'd1, 16'h0010);
        for (int i = 0; i < 4; i++) begin
            bus_rd(2'd0, r); chk("R9 streamed read", r, 16'h0011 + 16'(i));
        end
        // R5: wrap at top of buffer
        bus_wr(2'd2, 16'h0047); bus_wr(2'd1, 16'h00FF); bus_wr(2'd0, 16'h00EE);
        bus_rd(2'd1, r); chk("R5 wrap low", r, 16'h0000);
        bus_rd(2'd2, r); chk("R5 wrap high", r, 16'h0040);

        // R6 R7 R8: word mode writes
        word_mode = 1'b1;
        bus_wr(2'd2, 16'h0042); bus_wr(2'd1, 16'h0020);
        bus_wr(2'd0, 16'hBEEF);
        bus_rd(2'd1, r); chk("R8 advance by two", r, 16'h0022);
        bus_wr(2'd1, 16'h0023);
        bus_wr(2'd0, 16'h1234);
        bus_rd(2'd1, r); chk("R8 swap flag kept", r, 16'h0025);

        // R6 R7: byte-wise view of the word writes
        word_mode = 1'b0;
        bus_wr(2'd2, 16'h0082);
        bus_wr(2'd1, 16'h0020); bus_rd(2'd0, r); chk("R6 low lane", r, 16'h00EF);
        bus_wr(2'd1, 16'h0021); bus_rd(2'd0, r); chk("R6 high lane", r, 16'h00BE);
        bus_wr(2'd1, 16'h0022); bus_rd(2'd0, r); chk("R7 swapped write", r, 16'h0012);
        bus_wr(2'd1, 16'h0023); bus_rd(2'd0, r); chk("R7 swapped write hi", r, 16'h0034);

        // R6 R7 R8 R9: word mode reads
        word_mode = 1'b1;
        bus_wr(2'd2, 16'h00C2); bus_wr(2'd1, 16'h0020);
        bus_rd(2'd0, r); chk("R6 word read", r, 16'hBEEF);
        bus_rd(2'd0, r); chk("R9 R8 next word", r, 16'h3412);
        bus_wr(2'd1, 16'h0021);
        bus_rd(2'd0, r); chk("R7 swapped read", r, 16'hEFBE);
        word_mode = 1'b0;

        finish_run();
    end
endmodule